// File: doc/BRIEF.md
# Threshold-Interrupting Byte Count Monitor

This block watches a stream of bus beats, each of which reports how many bytes it moved, and adds those byte counts into a 32-bit running total. A beat is counted only when the monitor is running and the beat's identifier passes a mask/match qualifier. Software programs the block through a small word-addressed register bank: a control word holding the run bit and a 5-bit throttle-adjust value, a counter-zero command, the count itself, a threshold, the qualifier mask and match values, and a sticky status / enable / write-one-to-clear interrupt set.

When the running total reaches the programmed threshold the block sets a sticky threshold flag, and when the 32-bit total rolls over it sets a sticky overflow flag. Each flag can drive the local interrupt output through its own enable bit. Every enabled flag event also raises a single request line toward a chip-level interrupt aggregator; that line has its own acknowledge, separate from the local status clear. A build parameter selects between free-running behaviour, where the counter keeps accumulating past the threshold, and wrap-on-threshold behaviour, where the threshold is subtracted out at the hit so that software recovers the total by adding the threshold back.

The throttle-adjust field has no effect inside the block; it is held in the control word and driven out as a static output for a neighbouring throttle unit.

Top module: `byte_count_monitor`

## Requirements
- R1: Beats are counted only while CTRL (offset 0) bit 0 is 1; clearing that bit freezes the count without altering it.
- R2: CTRL bits 20:16 hold the throttle-adjust value, read back in place and driven on `throttle_o`, and are written independently of the value of bit 0.
- R3: A write with bit 0 set to ZERO (offset 1) makes the count 0 after the edge, and takes priority over a beat counted in the same cycle.
- R4: STAT (offset 6) bit 0 is the threshold flag and bit 1 the overflow flag; both are sticky across stopping, are cleared by writing ones to ICLR (offset 8), and a flag event in the same cycle as its clear leaves the flag set.
- R5: With WRAP_ON_LIMIT = 0, a threshold event occurs when a counted beat takes the count from below LIMIT (offset 3) to at least LIMIT; the count keeps accumulating, and LIMIT = 0 never produces an event.
- R6: With WRAP_ON_LIMIT = 1 and LIMIT nonzero, a counted beat that makes count + bytes at least LIMIT raises a threshold event and leaves count + bytes − LIMIT in the counter (zero when the threshold is reached exactly).
- R7: The count wraps modulo 2^32; a counted beat that carries past 2^32 − 1 raises an overflow event.
- R8: `irq_o` is high exactly when STAT AND IEN (offset 7, bit 0 threshold, bit 1 overflow) is nonzero.
- R9: `glb_req_o` rises after any flag event whose IEN bit is set and stays high until a write with bit 0 set to GACK (offset 9); a clear of STAT does not drop it, and a new enabled event in the acknowledge cycle wins.
- R10: A beat is qualified only when ((beat_id XOR MATCH) AND MASK) is zero, MASK at offset 4 and MATCH at offset 5; unqualified beats leave the count unchanged.
- R11: After reset every register, the count, the flags, `irq_o`, `glb_req_o` and `throttle_o` are zero.
- R12: COUNT (offset 2) reads the current total; ZERO, ICLR, GACK and unmapped offsets read as 0; register reads are combinational on `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_valid | input | 1 | A bus beat is present this cycle |
| beat_bytes | input | BYTES_W | Bytes moved by the beat |
| beat_id | input | ID_W | Identifier of the beat for the qualifier |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| throttle_o | output | 5 | Throttle-adjust value from CTRL |
| irq_o | output | 1 | Local interrupt |
| glb_req_o | output | 1 | Request to the global interrupt aggregator |

## Verification
Every cycle the assertions check that a stopped or unqualified cycle holds the count, that a zero command wins, that flags stay set until cleared and rise after their events, that the interrupt output is gated by the enables, and that the global request rises on enabled events and holds until acknowledged. The arithmetic itself — the exact value left after a wrap-mode threshold hit, the crossing rule in free-running mode, the modulo-2^32 total and the readback of each register — is only shown by the bench, whose behavioural model runs both build variants side by side against directed and random traffic and register writes.

// File: rtl/bytemon_pkg.sv
package bytemon_pkg;

  localparam int CNT_W  = 32;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int THR_LO = 16;
  localparam int THR_W  = 5;
  localparam int ST_W   = 2;
  localparam int ST_HIT = 0;
  localparam int ST_OVF = 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_ZERO  = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_LIMIT = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_MATCH = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_GACK  = 4'd9;

  typedef struct packed {
    logic [CNT_W-1:0] value;
    logic             hit;
    logic             ovf;
  } step_t;

  // One accumulation step: new counter value plus threshold and carry events.
  function automatic step_t count_step(input logic [CNT_W-1:0] cur,
                                       input logic [CNT_W-1:0] inc,
                                       input logic [CNT_W-1:0] lim,
                                       input logic             wrap);
    logic [CNT_W:0] sum;
    logic [CNT_W:0] res;
    logic           hit;
    step_t          r;
    sum = {1'b0, cur} + {1'b0, inc};
    if (wrap) hit = (lim != '0) && (sum >= {1'b0, lim});
    else      hit = (cur < lim) && (sum >= {1'b0, lim});
    res     = (hit && wrap) ? (sum - {1'b0, lim}) : sum;
    r.value = res[CNT_W-1:0];
    r.hit   = hit;
    r.ovf   = res[CNT_W];
    return r;
  endfunction

  function automatic logic id_selected(input logic [DATA_W-1:0] id,
                                       input logic [DATA_W-1:0] mask,
                                       input logic [DATA_W-1:0] match);
    return ((id ^ match) & mask) == '0;
  endfunction

endpackage

// File: rtl/bytemon_filter.sv
module bytemon_filter
  import bytemon_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            beat_valid,
  input  logic [ID_W-1:0] beat_id,
  input  logic            run,
  input  logic [ID_W-1:0] sel_mask,
  input  logic [ID_W-1:0] sel_match,
  output logic            qual
);
  localparam int PAD = DATA_W - ID_W;

  logic id_ok;

  always_comb begin
    id_ok = id_selected({{PAD{1'b0}}, beat_id},
                        {{PAD{1'b0}}, sel_mask},
                        {{PAD{1'b0}}, sel_match});
    qual  = beat_valid && run && id_ok;
  end
endmodule

// File: rtl/bytemon_counter.sv
module bytemon_counter
  import bytemon_pkg::*;
#(
  parameter int BYTES_W       = 8,
  parameter bit WRAP_ON_LIMIT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_req,
  input  logic               qual,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]   limit,
  output logic [CNT_W-1:0]   count,
  output logic               hit_evt,
  output logic               ovf_evt
);
  localparam int INC_PAD = CNT_W - BYTES_W;

  step_t            nxt;
  logic [CNT_W-1:0] inc;

  generate
    if (INC_PAD > 0) begin : g_pad
      assign inc = {{INC_PAD{1'b0}}, beat_bytes};
    end else begin : g_full
      assign inc = beat_bytes[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    nxt     = count_step(count, inc, limit, WRAP_ON_LIMIT);
    hit_evt = qual && !zero_req && nxt.hit;
    ovf_evt = qual && !zero_req && nxt.ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (zero_req) count <= '0;
    else if (qual)     count <= nxt.value;
  end
endmodule

// File: rtl/bytemon_irq.sv
module bytemon_irq
  import bytemon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  input  logic [ST_W-1:0] ien,
  input  logic            gack,
  output logic [ST_W-1:0] stat,
  output logic            irq,
  output logic            glb_req,
  output logic            armed_evt
);
  assign armed_evt = |(set_vec & ien);
  assign irq       = |(stat & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      glb_req <= 1'b0;
    end else begin
      stat <= (stat & ~clr_vec) | set_vec;
      if (armed_evt) glb_req <= 1'b1;
      else if (gack) glb_req <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_count_monitor.sv
module byte_count_monitor
  import bytemon_pkg::*;
#(
  parameter int BYTES_W       = 8,
  parameter int ID_W          = 8,
  parameter bit WRAP_ON_LIMIT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic [BYTES_W-1:0] beat_bytes,
  input  logic [ID_W-1:0]    beat_id,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic [4:0]         throttle_o,
  output logic               irq_o,
  output logic               glb_req_o
);
  localparam int ID_PAD = DATA_W - ID_W;

  logic             run;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] limit;
  logic [ID_W-1:0]  sel_mask;
  logic [ID_W-1:0]  sel_match;
  logic [ST_W-1:0]  ien;
  logic [CNT_W-1:0] count;
  logic [ST_W-1:0]  stat;

  // named internal events
  logic            ctrl_we, limit_we, mask_we, match_we, ien_we;
  logic            zero_req, gack_req;
  logic [ST_W-1:0] stat_clr;
  logic            qual, hit_evt, ovf_evt, armed_evt;
  logic [ST_W-1:0] set_vec;

  always_comb begin
    ctrl_we  = cfg_we && (cfg_addr == OFS_CTRL);
    limit_we = cfg_we && (cfg_addr == OFS_LIMIT);
    mask_we  = cfg_we && (cfg_addr == OFS_MASK);
    match_we = cfg_we && (cfg_addr == OFS_MATCH);
    ien_we   = cfg_we && (cfg_addr == OFS_IEN);
    zero_req = cfg_we && (cfg_addr == OFS_ZERO) && cfg_wdata[0];
    gack_req = cfg_we && (cfg_addr == OFS_GACK) && cfg_wdata[0];
    stat_clr = (cfg_we && (cfg_addr == OFS_ICLR)) ? cfg_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      thr       <= '0;
      limit     <= '0;
      sel_mask  <= '0;
      sel_match <= '0;
      ien       <= '0;
    end else begin
      if (ctrl_we) begin
        run <= cfg_wdata[0];
        thr <= cfg_wdata[THR_LO +: THR_W];
      end
      if (limit_we) limit     <= cfg_wdata[CNT_W-1:0];
      if (mask_we)  sel_mask  <= cfg_wdata[ID_W-1:0];
      if (match_we) sel_match <= cfg_wdata[ID_W-1:0];
      if (ien_we)   ien       <= cfg_wdata[ST_W-1:0];
    end
  end

  bytemon_filter #(.ID_W(ID_W)) u_filter (
    .beat_valid (beat_valid),
    .beat_id    (beat_id),
    .run        (run),
    .sel_mask   (sel_mask),
    .sel_match  (sel_match),
    .qual       (qual)
  );

  bytemon_counter #(.BYTES_W(BYTES_W), .WRAP_ON_LIMIT(WRAP_ON_LIMIT)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .zero_req   (zero_req),
    .qual       (qual),
    .beat_bytes (beat_bytes),
    .limit      (limit),
    .count      (count),
    .hit_evt    (hit_evt),
    .ovf_evt    (ovf_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_HIT] = hit_evt;
    set_vec[ST_OVF] = ovf_evt;
  end

  bytemon_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_vec   (stat_clr),
    .ien       (ien),
    .gack      (gack_req),
    .stat      (stat),
    .irq       (irq_o),
    .glb_req   (glb_req_o),
    .armed_evt (armed_evt)
  );

  assign throttle_o = thr;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_CTRL:  begin
        cfg_rdata[0]               = run;
        cfg_rdata[THR_LO +: THR_W] = thr;
      end
      OFS_COUNT: cfg_rdata = count;
      OFS_LIMIT: cfg_rdata = limit;
      OFS_MASK:  cfg_rdata = {{ID_PAD{1'b0}}, sel_mask};
      OFS_MATCH: cfg_rdata = {{ID_PAD{1'b0}}, sel_match};
      OFS_STAT:  cfg_rdata[ST_W-1:0] = stat;
      OFS_IEN:   cfg_rdata[ST_W-1:0] = ien;
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/byte_count_monitor_checker.sv
module byte_count_monitor_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        qual,
  input logic        zero_req,
  input logic        ctrl_we,
  input logic        gack_req,
  input logic [1:0]  stat_clr,
  input logic [31:0] count,
  input logic [1:0]  stat,
  input logic [1:0]  ien,
  input logic        hit_evt,
  input logic        ovf_evt,
  input logic [4:0]  throttle_o,
  input logic        irq_o,
  input logic        glb_req_o
);
  p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !zero_req) |=> $stable(count));

  p_throttle_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(throttle_o));

  p_zero_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (count == 32'd0));

  p_hit_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !stat_clr[0]) |=> stat[0]);

  p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !stat_clr[1]) |=> stat[1]);

  p_hit_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> stat[0]);

  p_ovf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> stat[1]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ien) == 2'b00) |-> !irq_o);

  p_glb_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((({ovf_evt, hit_evt}) & ien) != 2'b00) |=> glb_req_o);

  p_glb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_req_o && !gack_req) |=> glb_req_o);

  p_unqualified_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !zero_req) |=> $stable(count));
endmodule

bind byte_count_monitor byte_count_monitor_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .qual       (qual),
  .zero_req   (zero_req),
  .ctrl_we    (ctrl_we),
  .gack_req   (gack_req),
  .stat_clr   (stat_clr),
  .count      (count),
  .stat       (stat),
  .ien        (ien),
  .hit_evt    (hit_evt),
  .ovf_evt    (ovf_evt),
  .throttle_o (throttle_o),
  .irq_o      (irq_o),
  .glb_req_o  (glb_req_o)
);

// File: tb/byte_count_monitor_bench.sv
`timescale 1ns/1ps
module byte_count_monitor_bench;
  localparam int BW = 32;
  localparam int IW = 8;
  localparam longint TWO32 = 64'h1_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          beat_valid = 1'b0;
  logic [BW-1:0] beat_bytes = '0;
  logic [IW-1:0] beat_id = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_addr = 4'd2;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   rd0, rd1;
  logic [4:0]    thr0, thr1;
  logic          irq0, irq1, glb0, glb1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_count_monitor #(.BYTES_W(BW), .ID_W(IW), .WRAP_ON_LIMIT(1'b0)) u_byte_count_monitor (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .beat_id(beat_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd0), .throttle_o(thr0), .irq_o(irq0), .glb_req_o(glb0));

  byte_count_monitor #(.BYTES_W(BW), .ID_W(IW), .WRAP_ON_LIMIT(1'b1)) u_byte_count_monitor_wrap (
    .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .beat_id(beat_id), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd1), .throttle_o(thr1), .irq_o(irq1), .glb_req_o(glb1));

  // behavioural reference model: shared configuration, per-variant state
  int     m_run, m_thr, m_mask, m_match, m_ien;
  longint m_lim;
  longint m_cnt [2];
  int     m_stat [2];
  int     m_glb [2];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic longint model_read(input int k, input int a);
    case (a)
      0: return longint'(m_thr) * 65536 + m_run;
      2: return m_cnt[k];
      3: return m_lim;
      4: return m_mask;
      5: return m_match;
      6: return m_stat[k];
      7: return m_ien;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_thr = 0; m_mask = 0; m_match = 0; m_ien = 0; m_lim = 0;
      for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_stat[k] = 0; m_glb[k] = 0; end
    end else begin
      int a;
      bit z, q;
      a = int'(cfg_addr);
      z = cfg_we && a == 1 && cfg_wdata[0];
      q = beat_valid && m_run != 0 && (((int'(beat_id) ^ m_match) & m_mask) == 0);
      for (int k = 0; k < 2; k++) begin
        int set;
        int clr;
        set = 0;
        if (z) m_cnt[k] = 0;
        else if (q) begin
          longint s;
          bit h;
          s = m_cnt[k] + longint'(beat_bytes);
          if (k == 1) begin
            h = (m_lim != 0) && (s >= m_lim);
            if (h) s = s - m_lim;
          end else h = (m_cnt[k] < m_lim) && (s >= m_lim);
          if (s >= TWO32) set = set + 2;
          if (h) set = set + 1;
          m_cnt[k] = s % TWO32;
        end
        clr = (cfg_we && a == 8) ? int'(cfg_wdata[1:0]) : 0;
        m_stat[k] = (m_stat[k] & ~clr) | set;
        if ((set & m_ien) != 0) m_glb[k] = 1;
        else if (cfg_we && a == 9 && cfg_wdata[0]) m_glb[k] = 0;
      end
      if (cfg_we) begin
        case (a)
          0: begin m_run = int'(cfg_wdata[0]); m_thr = int'(cfg_wdata[20:16]); end
          3: m_lim = longint'(cfg_wdata);
          4: m_mask = int'(cfg_wdata[7:0]);
          5: m_match = int'(cfg_wdata[7:0]);
          7: m_ien = int'(cfg_wdata[1:0]);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R12 readback plain", rd0, model_read(0, int'(cfg_addr)));
      chk("R12 readback wrap", rd1, model_read(1, int'(cfg_addr)));
      chk("R8 irq plain", irq0, ((m_stat[0] & m_ien) != 0));
      chk("R8 irq wrap", irq1, ((m_stat[1] & m_ien) != 0));
      chk("R9 glb plain", glb0, m_glb[0]);
      chk("R9 glb wrap", glb1, m_glb[1]);
      chk("R2 throttle", thr0, m_thr);
      chk("R2 throttle wrap", thr1, m_thr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cyc(input bit we, input int a, input logic [31:0] wd,
                     input bit bv, input logic [BW-1:0] nb, input logic [IW-1:0] id);
    cfg_we = we; cfg_addr = a[3:0]; cfg_wdata = wd;
    beat_valid = bv; beat_bytes = nb; beat_id = id;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 4'd2; cfg_wdata = '0;
    beat_valid = 1'b0; beat_bytes = '0; beat_id = '0;
  endtask

  task automatic wr(input int a, input logic [31:0] wd);
    cyc(1'b1, a, wd, 1'b0, '0, '0);
  endtask

  task automatic beat(input logic [BW-1:0] nb, input logic [IW-1:0] id);
    cyc(1'b0, 2, '0, 1'b1, nb, id);
  endtask

  task automatic peek(input int a, output logic [31:0] v0, output logic [31:0] v1);
    cfg_addr = a[3:0];
    #1;
    v0 = rd0; v1 = rd1;
    @(negedge clk);
    cfg_addr = 4'd2;
  endtask

  initial begin
    logic [31:0] v0, v1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int a = 0; a < 10; a++) begin
      peek(a, v0, v1);
      chk("R11 reset reg plain", v0, 0);
      chk("R11 reset reg wrap", v1, 0);
    end
    chk("R11 reset irq", irq0 | irq1 | glb0 | glb1, 0);
    chk("R11 reset throttle", thr0, 0);

    // R2 throttle with run, R1 counting
    wr(0, 32'h0013_0001);
    chk("R2 throttle out", thr0, 5'h13);
    peek(0, v0, v1);
    chk("R2 ctrl readback", v0, 32'h0013_0001);
    for (int i = 0; i < 5; i++) beat(10, 8'h00);
    chk("R1 count while running", rd0, 50);
    chk("R1 count while running wrap", rd1, 50);

    // R1 stop keeps count, R2 field kept
    wr(0, 32'h0013_0000);
    for (int i = 0; i < 4; i++) beat(10, 8'h00);
    chk("R1 frozen when stopped", rd0, 50);
    chk("R2 throttle kept when stopped", thr1, 5'h13);

    // R3 zero beats a same-cycle beat
    wr(0, 32'h0013_0001);
    cyc(1'b1, 1, 32'h1, 1'b1, 32'd40, 8'h00);
    chk("R3 zero priority", rd0, 0);
    chk("R3 zero priority wrap", rd1, 0);

    // R5 / R6 threshold in both modes
    wr(3, 32'd100);
    wr(7, 32'h1);
    for (int i = 0; i < 4; i++) beat(30, 8'h00);
    chk("R5 free-run continues", rd0, 120);
    chk("R6 wrap remainder", rd1, 20);
    chk("R8 irq on hit", irq0 & irq1, 1);
    chk("R9 glb on hit", glb0 & glb1, 1);
    beat(80, 8'h00);
    chk("R6 wrap exact reaches zero", rd1, 0);
    chk("R5 free-run no second crossing", rd0, 200);

    // R4 sticky after stop; clear separate from glb
    wr(0, 32'h0013_0000);
    peek(6, v0, v1);
    chk("R4 sticky when stopped", v0, 1);
    wr(8, 32'h1);
    peek(6, v0, v1);
    chk("R4 w1c clears", v0 | v1, 0);
    chk("R8 irq drops", irq0 | irq1, 0);
    chk("R9 glb survives status clear", glb0 & glb1, 1);
    wr(9, 32'h1);
    chk("R9 glb ack", glb0 | glb1, 0);

    // R10 filter
    wr(3, 32'd0);
    wr(1, 32'h1);
    wr(4, 32'h0F);
    wr(5, 32'h05);
    wr(0, 32'h0000_0001);
    beat(7, 8'h15);
    beat(9, 8'h16);
    beat(3, 8'hA5);
    chk("R10 filter plain", rd0, 10);
    chk("R10 filter wrap", rd1, 10);
    wr(4, 32'h00);

    // R7 overflow
    wr(7, 32'h3);
    wr(1, 32'h1);
    beat(32'hF000_0000, 8'h00);
    beat(32'hF000_0000, 8'h00);
    chk("R7 modulo count", rd0, 32'hE000_0000);
    peek(6, v0, v1);
    chk("R7 overflow flag", v0, 2);
    chk("R7 overflow flag wrap", v1, 2);

    // R4 set wins over same-cycle clear
    cyc(1'b1, 8, 32'h3, 1'b1, 32'h2000_0000, 8'h00);
    chk("R7 exact roll to zero", rd0, 0);
    peek(6, v0, v1);
    chk("R4 set beats clear", v0, 2);
    wr(8, 32'h3);
    wr(9, 32'h1);

    // R12 write-only offsets read zero
    peek(1, v0, v1);  chk("R12 zero reads 0", v0, 0);
    peek(8, v0, v1);  chk("R12 iclr reads 0", v0, 0);
    peek(12, v0, v1); chk("R12 unmapped reads 0", v1, 0);

    // mixed random traffic against the model (R1..R10)
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0)      wr(3, 32'd50 + ($urandom % 250));
      else if (r == 1) wr(8, $urandom % 4);
      else if (r == 2) wr(9, 32'h1);
      else if (r == 3) wr(0, {11'd0, 5'($urandom), 15'd0, 1'($urandom % 4 != 0)});
      else if (r == 4) wr(4, $urandom % 4);
      else if (r == 5) cyc(1'b1, 1, 32'h1, 1'b1, 32'd5, 8'h00);
      else             beat($urandom % 64, 8'($urandom));
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule